// File: doc/BRIEF.md
# Cartridge Bus to USB Byte-FIFO Bridge

This bridge connects a console's 16-bit, word-addressed cartridge expansion bus to an external parallel byte FIFO that carries USB traffic. It decodes a small address window into two active-low port selects. One select is for a data port and one is for a status port. A host write to the data port becomes a timed write strobe on the FIFO. A host read of the data port becomes a single timed read strobe, and the captured byte is returned in the low lane of the bus word.

The console's bus bridge turns every read into two back-to-back word reads. Address bit 1 is low on the first of the pair and high on the second. In the default configuration the bridge pops the FIFO only on the first half and replays the same byte on the second half. As a build option, the window can instead be decoded in the upper half of the address space, selected by the top address bit. The host does not double reads there, so every data-port read pops.

The bus is assumed synchronous to `clk`. An access begins on the cycle its strobe becomes active inside the window. The host holds its strobe until `host_busy` is low.

Top module: `cbf_bridge`

## Requirements
- R1: `dat_sel_n` is low exactly when `host_cs_n` is low, address bits [18:3] equal `WIN_TAG`, the top address bit matches the region, and bit 2 is 0. `sts_sel_n` follows the same rule with bit 2 equal to 1. Both selects idle high and are never low together.
- R2: With `NODUP`=0 the window is decoded with address bit 19 = 0. With `NODUP`=1 it is decoded with bit 19 = 1.
- R3: A data-port read with address bit 1 = 0 and a non-empty FIFO drives `fifo_rd_n` low for exactly `STROBE_CYC` cycles, once. It returns the byte present on `fifo_din` at the end of that window in `host_rdata[7:0]`, with `host_rdata[15:8]` = 0.
- R4: With `NODUP`=0, a data-port read with address bit 1 = 1 produces no read strobe and returns the byte of the previous first-half read. With `NODUP`=1, every data-port read pops, whatever bit 1 is.
- R5: A data-port read while `fifo_rx_empty` is 1 returns 0x00 and produces no read strobe.
- R6: A write to the data port with `host_wr_lo_n` low and the FIFO not full produces one `fifo_wr_n` low pulse of exactly `STROBE_CYC` cycles. `fifo_wdata` equals `host_wdata[7:0]` from one cycle before the falling edge until after the rising edge.
- R7: Writes with only `host_wr_hi_n` low, and any write to the status port, produce no FIFO strobe.
- R8: A data-port write with the low lane while `fifo_tx_full` is 1 produces no strobe and sets a sticky overflow flag.
- R9: A status read returns a byte with bit 0 = not empty, bit 1 = not full, bit 2 = overflow and bit 6 = `fifo_pwr_en`, and every other bit 0. The status read clears the overflow flag.
- R10: After reset both FIFO strobes are high, `host_busy` is low, `host_rdata` is 0 and overflow is clear.
- R11: `fifo_rd_n` and `fifo_wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Cartridge region select from the host, active low |
| host_addr | input | ADDR_W | Host address lines, bit 0 unused |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_lo_n | input | 1 | Host low-byte write strobe, active low |
| host_wr_hi_n | input | 1 | Host high-byte write strobe, active low |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, low byte valid |
| host_busy | output | 1 | Access in progress, host holds its strobe |
| dat_sel_n | output | 1 | Data port select, active low |
| sts_sel_n | output | 1 | Status port select, active low |
| fifo_din | input | 8 | Byte from the FIFO |
| fifo_rx_empty | input | 1 | FIFO has no received byte |
| fifo_tx_full | input | 1 | FIFO cannot accept a byte |
| fifo_pwr_en | input | 1 | USB side powered and configured |
| fifo_rd_n | output | 1 | FIFO read strobe, active low |
| fifo_wr_n | output | 1 | FIFO write strobe, active low |
| fifo_wdata | output | 8 | Byte to the FIFO |

## Verification
The hardest case to reach is the second half of a doubled read while the FIFO still holds data. A faulty gate there pops a second byte and loses it silently. The bench reaches it by issuing a first-half read and then a bit-1-high read with `fifo_rx_empty` kept low. It then checks that the pop count did not move and that the replayed byte matches. The sticky overflow is reached by raising `fifo_tx_full` in the bench before a low-lane write. Two status reads follow, and the bench expects bit 2 set and then clear.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WSU  = 2'd2,
    SEQ_WR   = 2'd3
  } seq_st_t;

  localparam int STS_RX_AVAIL = 0;
  localparam int STS_TX_SPACE = 1;
  localparam int STS_OVF      = 2;
  localparam int STS_PWR      = 6;
endpackage

// File: rtl/cbf_decode.sv
module cbf_decode #(
  parameter int ADDR_W = 20,
  parameter bit NODUP = 1'b0,
  parameter logic [ADDR_W-5:0] WIN_TAG = '0
) (
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              dat_sel_n,
  output logic              sts_sel_n,
  output logic              dup_half
);
  localparam logic REGION = NODUP;

  logic in_win;

  always_comb begin
    in_win    = !cs_n && (addr[ADDR_W-1] == REGION) && (addr[ADDR_W-2:3] == WIN_TAG);
    dat_sel_n = !(in_win && !addr[2]);
    sts_sel_n = !(in_win && addr[2]);
  end

  generate
    if (NODUP) begin : g_nodup
      assign dup_half = 1'b0;
    end else begin : g_dup
      assign dup_half = addr[1];
    end
  endgenerate
endmodule

// File: rtl/cbf_status.sv
module cbf_status
  import cbf_pkg::*;
(
  input  logic       rx_empty,
  input  logic       tx_full,
  input  logic       pwr_en,
  input  logic       ovf,
  output logic [7:0] sts_byte
);
  always_comb begin
    sts_byte               = 8'h00;
    sts_byte[STS_RX_AVAIL] = !rx_empty;
    sts_byte[STS_TX_SPACE] = !tx_full;
    sts_byte[STS_OVF]      = ovf;
    sts_byte[STS_PWR]      = pwr_en;
  end
endmodule

// File: rtl/cbf_strobe_seq.sv
module cbf_strobe_seq
  import cbf_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop_go,
  input  logic       push_go,
  input  logic [7:0] push_data,
  output logic       pop_done,
  output logic       busy,
  output logic       fifo_rd_n,
  output logic       fifo_wr_n,
  output logic [7:0] fifo_wdata
);
  localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STROBE_CYC - 1);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wd_en;
  logic          rd_n_d, wr_n_d, busy_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    wd_en = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (pop_go) begin
          st_d  = SEQ_RD;
          cnt_d = LOAD;
        end else if (push_go) begin
          st_d  = SEQ_WSU;
          wd_en = 1'b1;
        end
      end
      SEQ_WSU: begin
        st_d  = SEQ_WR;
        cnt_d = LOAD;
      end
      SEQ_RD, SEQ_WR: begin
        if (cnt_q == '0) st_d = SEQ_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SEQ_IDLE;
    endcase
    rd_n_d = (st_d != SEQ_RD);
    wr_n_d = (st_d != SEQ_WR);
    busy_d = (st_d != SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      cnt_q     <= '0;
      fifo_rd_n <= 1'b1;
      fifo_wr_n <= 1'b1;
      busy      <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      fifo_rd_n <= rd_n_d;
      fifo_wr_n <= wr_n_d;
      busy      <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fifo_wdata <= 8'h00;
    else if (wd_en) fifo_wdata <= push_data;
  end

  assign pop_done = (st_q == SEQ_RD) && (cnt_q == '0);
endmodule

// File: rtl/cbf_bridge.sv
module cbf_bridge
  import cbf_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter bit NODUP = 1'b0,
  parameter logic [ADDR_W-5:0] WIN_TAG = 'h0A5C,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd_n,
  input  logic              host_wr_lo_n,
  input  logic              host_wr_hi_n,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_busy,
  output logic              dat_sel_n,
  output logic              sts_sel_n,
  input  logic [7:0]        fifo_din,
  input  logic              fifo_rx_empty,
  input  logic              fifo_tx_full,
  input  logic              fifo_pwr_en,
  output logic              fifo_rd_n,
  output logic              fifo_wr_n,
  output logic [7:0]        fifo_wdata
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic dup_half;
  logic [7:0] sts_byte;
  logic unused_bits;
  assign unused_bits = ^{host_wdata[15:8], host_addr[0]};

  cbf_decode #(
    .ADDR_W (ADDR_W),
    .NODUP  (NODUP),
    .WIN_TAG(WIN_TAG)
  ) u_decode (
    .cs_n     (host_cs_n),
    .addr     (host_addr),
    .dat_sel_n(dat_sel_n),
    .sts_sel_n(sts_sel_n),
    .dup_half (dup_half)
  );

  logic ovf_q, ovf_d;

  cbf_status u_status (
    .rx_empty(fifo_rx_empty),
    .tx_full (fifo_tx_full),
    .pwr_en  (fifo_pwr_en),
    .ovf     (ovf_q),
    .sts_byte(sts_byte)
  );

  logic rd_act, wr_act, rd_act_q, wr_act_q;
  logic rd_start, wr_start, dat_rd, sts_rd, dat_wr;
  logic pop_go, push_go, pop_done, seq_busy;
  logic [7:0] rd_byte_q, rd_byte_d;
  logic rd_byte_en;

  always_comb begin
    rd_act   = !host_rd_n && (!dat_sel_n || !sts_sel_n);
    wr_act   = (!host_wr_lo_n || !host_wr_hi_n) && (!dat_sel_n || !sts_sel_n);
    rd_start = rd_act && !rd_act_q && !seq_busy;
    wr_start = wr_act && !wr_act_q && !seq_busy;
    dat_rd   = rd_start && !dat_sel_n;
    sts_rd   = rd_start && !sts_sel_n;
    dat_wr   = wr_start && !dat_sel_n && !host_wr_lo_n;
    pop_go   = dat_rd && !dup_half && !fifo_rx_empty;
    push_go  = dat_wr && !fifo_tx_full;

    ovf_d = (ovf_q && !sts_rd) || (dat_wr && fifo_tx_full);

    rd_byte_en = 1'b1;
    rd_byte_d  = rd_byte_q;
    if (pop_done)                               rd_byte_d = fifo_din;
    else if (sts_rd)                            rd_byte_d = sts_byte;
    else if (dat_rd && !dup_half && fifo_rx_empty) rd_byte_d = 8'h00;
    else                                        rd_byte_en = 1'b0;
  end

  cbf_strobe_seq #(
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .pop_go    (pop_go),
    .push_go   (push_go),
    .push_data (host_wdata[7:0]),
    .pop_done  (pop_done),
    .busy      (seq_busy),
    .fifo_rd_n (fifo_rd_n),
    .fifo_wr_n (fifo_wr_n),
    .fifo_wdata(fifo_wdata)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        rd_byte_q <= 8'h00;
    else if (rd_byte_en) rd_byte_q <= rd_byte_d;
  end

  assign host_rdata = {8'h00, rd_byte_q};
  assign host_busy  = seq_busy;
endmodule

// File: rtl/cbf_bridge_chk.sv
module cbf_bridge_chk #(
  parameter int ADDR_W = 20,
  parameter bit NODUP = 1'b0,
  parameter int STROBE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              dat_sel_n,
  input logic              sts_sel_n,
  input logic              fifo_rx_empty,
  input logic              fifo_tx_full,
  input logic              fifo_rd_n,
  input logic              fifo_wr_n,
  input logic [7:0]        fifo_wdata
);
  logic [7:0] rd_low_cnt, wr_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_low_cnt <= 8'd0;
      wr_low_cnt <= 8'd0;
    end else begin
      rd_low_cnt <= fifo_rd_n ? 8'd0 : ((rd_low_cnt == 8'hFF) ? rd_low_cnt : rd_low_cnt + 8'd1);
      wr_low_cnt <= fifo_wr_n ? 8'd0 : ((wr_low_cnt == 8'hFF) ? wr_low_cnt : wr_low_cnt + 8'd1);
    end
  end

  // R1
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dat_sel_n && !sts_sel_n));

  // R2
  sel_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_sel_n || !sts_sel_n) |-> (host_addr[ADDR_W-1] == NODUP));

  // R3
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rd_n) |-> (rd_low_cnt == 8'(STROBE_CYC)));

  // R4
  rd_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!NODUP && $fell(fifo_rd_n)) |-> !$past(host_addr[1]));

  // R5
  rd_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rd_n) |-> !$past(fifo_rx_empty));

  // R6
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_wr_n) |-> (wr_low_cnt == 8'(STROBE_CYC)));

  // R6
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_wr_n || $rose(fifo_wr_n)) |-> $stable(fifo_wdata));

  // R8
  wr_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_wr_n) |-> !$past(fifo_tx_full, 2));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fifo_rd_n && !fifo_wr_n));
endmodule

bind cbf_bridge cbf_bridge_chk #(
  .ADDR_W    (ADDR_W),
  .NODUP     (NODUP),
  .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .host_addr    (host_addr),
  .dat_sel_n    (dat_sel_n),
  .sts_sel_n    (sts_sel_n),
  .fifo_rx_empty(fifo_rx_empty),
  .fifo_tx_full (fifo_tx_full),
  .fifo_rd_n    (fifo_rd_n),
  .fifo_wr_n    (fifo_wr_n),
  .fifo_wdata   (fifo_wdata)
);

// File: tb/cbf_bridge_bench.sv
`timescale 1ns/1ps
module cbf_bridge_bench;
  localparam int S = 2;
  localparam logic [15:0] TAG = 16'h0A5C;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2 clk = ~clk;

  logic        host_cs_n = 1'b1;
  logic [19:0] host_addr = '0;
  logic        host_rd_n = 1'b1, host_wr_lo_n = 1'b1, host_wr_hi_n = 1'b1;
  logic [15:0] host_wdata = '0;
  logic [7:0]  fifo_din;
  logic        rx_empty = 1'b0, tx_full = 1'b0, pwr = 1'b0;

  logic [15:0] rdata1, rdata2;
  logic busy1, busy2, dsel1, ssel1, dsel2, ssel2;
  logic rd1, wr1, rd2, wr2;
  logic [7:0] wd1, wd2;

  cbf_bridge #(.NODUP(1'b0), .STROBE_CYC(S)) u_cbf_bridge (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_lo_n(host_wr_lo_n), .host_wr_hi_n(host_wr_hi_n),
    .host_wdata(host_wdata), .host_rdata(rdata1), .host_busy(busy1),
    .dat_sel_n(dsel1), .sts_sel_n(ssel1), .fifo_din(fifo_din),
    .fifo_rx_empty(rx_empty), .fifo_tx_full(tx_full), .fifo_pwr_en(pwr),
    .fifo_rd_n(rd1), .fifo_wr_n(wr1), .fifo_wdata(wd1));

  cbf_bridge #(.NODUP(1'b1), .STROBE_CYC(S)) u_cbf_bridge_nodup (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_lo_n(host_wr_lo_n), .host_wr_hi_n(host_wr_hi_n),
    .host_wdata(host_wdata), .host_rdata(rdata2), .host_busy(busy2),
    .dat_sel_n(dsel2), .sts_sel_n(ssel2), .fifo_din(fifo_din),
    .fifo_rx_empty(rx_empty), .fifo_tx_full(tx_full), .fifo_pwr_en(pwr),
    .fifo_rd_n(rd2), .fifo_wr_n(wr2), .fifo_wdata(wd2));

  // FIFO model: byte sequence advances after each read pulse
  logic rd_any, wr_any;
  assign rd_any = rd1 & rd2;
  assign wr_any = wr1 & wr2;
  logic [7:0] cur_byte = 8'h3C;
  assign fifo_din = cur_byte;
  int pops = 0, pushes = 0, rd_low = 0, wr_low = 0;
  logic [7:0] wr_cap_fall = '0, wr_cap_rise = '0;
  always @(negedge rd_any) pops++;
  always @(posedge rd_any) cur_byte = cur_byte * 8'd7 + 8'd3;
  always @(negedge wr_any) begin pushes++; wr_cap_fall = wr1 ? wd2 : wd1; end
  always @(posedge wr_any) wr_cap_rise = wd1 | wd2;
  always @(negedge clk) begin
    if (!rd_any) rd_low++;
    if (!wr_any) wr_low++;
  end

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input bit hi, input logic [15:0] tag, input bit port, input bit half);
    return {hi, tag, port, half, 1'b0};
  endfunction

  task automatic do_read(input logic [19:0] a, input bit nd, output logic [15:0] d);
    host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
    @(negedge clk);
    while (nd ? busy2 : busy1) @(negedge clk);
    d = nd ? rdata2 : rdata1;
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [19:0] a, input bit lo, input bit hi, input logic [15:0] w);
    host_addr = a; host_wdata = w; host_cs_n = 1'b0;
    host_wr_lo_n = !lo; host_wr_hi_n = !hi;
    @(negedge clk);
    while (busy1 || busy2) @(negedge clk);
    host_wr_lo_n = 1'b1; host_wr_hi_n = 1'b1; host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] sts_exp(input bit ov);
    return {8'h00, 1'b0, pwr, 3'b000, ov, !tx_full, !rx_empty};
  endfunction

  initial begin
    logic [15:0] d, last;
    int p0, l0, w0, wl0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 rd strobe", rd1, 1'b1);
    check("R10 wr strobe", wr1, 1'b1);
    check("R10 busy", busy1, 1'b0);
    check("R10 rdata", rdata1, 16'h0000);
    do_read(mk(0, TAG, 1, 0), 0, d);
    check("R10 overflow clear", d[2], 1'b0);

    // R1 R2 select sweep, both regions
    for (int cs = 0; cs < 2; cs++)
      for (int hi = 0; hi < 2; hi++)
        for (int tv = 0; tv < 3; tv++)
          for (int lb = 0; lb < 8; lb++) begin
            logic [15:0] tg;
            bit m1, m2;
            tg = (tv == 0) ? TAG : (tv == 1) ? (TAG ^ 16'h0001) : (TAG ^ 16'h8000);
            host_cs_n = cs[0];
            host_addr = {hi[0], tg, lb[2:0]};
            #1;
            m1 = (cs == 0) && (hi == 0) && (tv == 0);
            m2 = (cs == 0) && (hi == 1) && (tv == 0);
            check("R1 dat_sel", dsel1, !(m1 && lb[2] == 0));
            check("R1 sts_sel", ssel1, !(m1 && lb[2] == 1));
            check("R2 nodup dat_sel", dsel2, !(m2 && lb[2] == 0));
            check("R2 nodup sts_sel", ssel2, !(m2 && lb[2] == 1));
            @(negedge clk);
          end
    host_cs_n = 1'b1;

    // R3 R4 R5 data read sweep in doubled region
    last = 16'h0000;
    for (int e = 0; e < 2; e++)
      for (int h = 0; h < 2; h++) begin
        logic [7:0] b;
        rx_empty = e[0];
        b = cur_byte; p0 = pops; l0 = rd_low;
        do_read(mk(0, TAG, 0, h[0]), 0, d);
        if (h == 0) begin
          check(e ? "R5 empty data" : "R3 data", d, e ? 16'h0000 : {8'h00, b});
          check(e ? "R5 no pop" : "R3 one pop", pops - p0, e ? 0 : 1);
          check("R3 pulse width", rd_low - l0, e ? 0 : S);
          last = d;
        end else begin
          check("R4 replay", d, last);
          check("R4 no second pop", pops - p0, 0);
        end
      end
    rx_empty = 1'b0;

    // R4 first/second half pairs with data present
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      logic [15:0] d2;
      b = cur_byte; p0 = pops;
      do_read(mk(0, TAG, 0, 0), 0, d);
      do_read(mk(0, TAG, 0, 1), 0, d2);
      check("R4 pair first", d, {8'h00, b});
      check("R4 pair second", d2, {8'h00, b});
      check("R4 pair pops", pops - p0, 1);
    end

    // R4 no-doubling region pops on both halves
    for (int h = 0; h < 2; h++) begin
      logic [7:0] b;
      b = cur_byte; p0 = pops;
      do_read(mk(1, TAG, 0, h[0]), 1, d);
      check("R4 nodup data", d, {8'h00, b});
      check("R4 nodup pop", pops - p0, 1);
    end

    // R9 status sweep
    for (int v = 0; v < 8; v++) begin
      rx_empty = v[0]; tx_full = v[1]; pwr = v[2];
      do_read(mk(0, TAG, 1, 0), 0, d);
      check("R9 status", d, sts_exp(0));
    end
    rx_empty = 1'b0; tx_full = 1'b0; pwr = 1'b1;

    // R6 R7 R8 write sweep
    for (int port = 0; port < 2; port++)
      for (int ln = 1; ln < 4; ln++)
        for (int f = 0; f < 2; f++) begin
          logic [15:0] w;
          bit go, ov;
          w = 16'(16'hA100 + port * 64 + ln * 8 + f * 3 + 5);
          tx_full = f[0];
          p0 = pushes; wl0 = wr_low; w0 = pops;
          do_write(mk(0, TAG, port[0], 0), ln[0], ln[1], w);
          go = (port == 0) && ln[0] && (f == 0);
          ov = (port == 0) && ln[0] && (f == 1);
          check(go ? "R6 push" : (ov ? "R8 dropped" : "R7 ignored"), pushes - p0, go ? 1 : 0);
          check(go ? "R6 width" : "R7 no strobe", wr_low - wl0, go ? S : 0);
          if (go) begin
            check("R6 data at fall", wr_cap_fall, w[7:0]);
            check("R6 data at rise", wr_cap_rise, w[7:0]);
          end
          check("R11 no pop on write", pops - w0, 0);
          tx_full = 1'b0;
          do_read(mk(0, TAG, 1, 0), 0, d);
          check(ov ? "R8 overflow set" : "R8 overflow clear", d, sts_exp(ov));
          do_read(mk(0, TAG, 1, 0), 0, d);
          check("R9 overflow cleared", d[2], 1'b0);
        end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule